// File: doc/BRIEF.md
# Segmented Slice Steering Decoder

This block turns a binary mixer coefficient into the switch-enable pattern of a sliced charge-sharing multiplier. The multiplier is split into a large array of identical unit slices plus a few binary-weighted fractional slices that carry one half and one quarter of a unit. The upper bits of the coefficient select how many unit slices to use with a thermometer decode. The lowest bits drive the fractional slices directly. The block also produces, for every slice, a pair of complementary steering enables that route its charge to the positive or to the negative output.

During the mix phase every slice is sent to exactly one side. The charge weight on the positive side therefore equals the coefficient, and the rest of the sampled charge goes to the negative side. Outside the mix phase, during reset and sampling, all steering enables are held low. The steering enables are registered, so that all of them switch together on one clock edge.

Top module: `slice_steer_decoder`

## Requirements
- R1: `unary_o[i]` is 1 exactly when `i` is less than the unsigned value of `code_i[CODE_W-1:FRAC_W]`, with no clock delay (8 upper bits and 256 unit slices by default).
- R2: `frac_o` equals `code_i[FRAC_W-1:0]` with no clock delay. `frac_o[1]` drives the half-unit slice and `frac_o[0]` drives the quarter-unit slice.
- R3: `pos_o` and `neg_o` are registered. After a rising edge they reflect the `code_i` and `mix_i` sampled at that edge, and they do not change between edges.
- R4: Slice order in the steering vectors: bits `[N_UNIT-1:0]` are the unit slices, bit `N_UNIT` is the quarter-unit slice and bit `N_UNIT+1` is the half-unit slice. With `mix_i` sampled high, `pos_o` equals `{frac, unary}` decoded from the sampled code.
- R5: With `mix_i` sampled high, `neg_o` is the bitwise complement of `pos_o`, so every slice is on exactly one side.
- R6: With `mix_i` sampled low, `pos_o` and `neg_o` are all zero whatever the code.
- R7: In quarter-unit weights (4 per unit slice, 2 for the half slice, 1 for the quarter slice), the weight of `pos_o` equals the sampled code. The weight of `neg_o` equals the total slice weight (1027 by default) minus the code.
- R8: While `rst_n` is low, `pos_o` and `neg_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_i | input | CODE_W | Mixer coefficient (10 bits) |
| mix_i | input | 1 | High during the mix phase |
| unary_o | output | 2**(CODE_W-FRAC_W) | Thermometer enables of the unit slices |
| frac_o | output | FRAC_W | Enables of the fractional slices |
| pos_o | output | 2**(CODE_W-FRAC_W)+FRAC_W | Registered positive-side steering enables |
| neg_o | output | 2**(CODE_W-FRAC_W)+FRAC_W | Registered negative-side steering enables |

## Verification
The bench builds the block with its default parameters: a 10-bit code, 2 fractional bits and 256 unit slices. With this configuration a full sweep of all 1024 codes is cheap. Every code is applied with the mix strobe both high and low, so every thermometer boundary and every fractional combination is reached, including the extremes where no unit slice, or all but one, goes positive. A final phase alternates the strobe on consecutive cycles with descending codes. This exposes any latency slip between the steering registers and the strobe.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  localparam int unsigned SSD_CODE_W = 10;
  localparam int unsigned SSD_FRAC_W = 2;

  // weight of fractional slice idx, in units of the smallest slice
  function automatic int unsigned frac_weight(input int unsigned idx);
    return 32'd1 << idx;
  endfunction

  // weight of one unit slice, in units of the smallest slice
  function automatic int unsigned unit_weight(input int unsigned frac_w);
    return 32'd1 << frac_w;
  endfunction

  // total weight of all slices together
  function automatic int unsigned full_weight(input int unsigned code_w,
                                              input int unsigned frac_w);
    return (32'd1 << code_w) + (32'd1 << frac_w) - 32'd1;
  endfunction
endpackage

// File: rtl/ssd_therm_dec.sv
module ssd_therm_dec #(
  parameter int unsigned IN_W = 8,
  localparam int unsigned OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  count_i,
  output logic [OUT_N-1:0] therm_o
);
  // one magnitude compare per unit slice
  for (genvar i = 0; i < OUT_N; i++) begin : g_bit
    localparam logic [IN_W:0] IDX = (IN_W+1)'(i);
    assign therm_o[i] = ({1'b0, count_i} > IDX);
  end
endmodule

// File: rtl/ssd_wsum.sv
module ssd_wsum #(
  parameter int unsigned N_UNIT = 256,
  parameter int unsigned FRAC_W = 2,
  parameter int unsigned SUM_W  = 11
) (
  input  logic [N_UNIT+FRAC_W-1:0] vec_i,
  output logic [SUM_W-1:0]         sum_o
);
  localparam logic [SUM_W-1:0] UNIT_WT = SUM_W'(ssd_pkg::unit_weight(FRAC_W));

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < int'(N_UNIT); k++) begin
      if (vec_i[k]) sum_o = sum_o + UNIT_WT;
    end
    for (int j = 0; j < int'(FRAC_W); j++) begin
      if (vec_i[N_UNIT+j]) sum_o = sum_o + SUM_W'(ssd_pkg::frac_weight(j));
    end
  end
endmodule

// File: rtl/ssd_steer_reg.sv
module ssd_steer_reg #(
  parameter int unsigned W = 258
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mix_i,
  input  logic [W-1:0] sel_i,
  output logic [W-1:0] pos_o,
  output logic [W-1:0] neg_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_o <= '0;
      neg_o <= '0;
    end else if (mix_i) begin
      pos_o <= sel_i;
      neg_o <= ~sel_i;
    end else begin
      pos_o <= '0;
      neg_o <= '0;
    end
  end
endmodule

// File: rtl/slice_steer_decoder.sv
module slice_steer_decoder #(
  parameter int unsigned CODE_W = ssd_pkg::SSD_CODE_W,
  parameter int unsigned FRAC_W = ssd_pkg::SSD_FRAC_W,
  localparam int unsigned UNARY_W = CODE_W - FRAC_W,
  localparam int unsigned N_UNIT  = 1 << UNARY_W,
  localparam int unsigned N_SLICE = N_UNIT + FRAC_W,
  localparam int unsigned TOTAL   = ssd_pkg::full_weight(CODE_W, FRAC_W),
  localparam int unsigned SUM_W   = $clog2(TOTAL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CODE_W-1:0]  code_i,
  input  logic               mix_i,
  output logic [N_UNIT-1:0]  unary_o,
  output logic [FRAC_W-1:0]  frac_o,
  output logic [N_SLICE-1:0] pos_o,
  output logic [N_SLICE-1:0] neg_o
);
  logic [N_SLICE-1:0] sel_vec;
  logic [SUM_W-1:0]   pos_wsum;  // observation wire for the checker
  logic [SUM_W-1:0]   neg_wsum;  // observation wire for the checker

  ssd_therm_dec #(.IN_W(UNARY_W)) u_therm (
    .count_i (code_i[CODE_W-1:FRAC_W]),
    .therm_o (unary_o)
  );

  assign frac_o  = code_i[FRAC_W-1:0];
  assign sel_vec = {frac_o, unary_o};

  ssd_steer_reg #(.W(N_SLICE)) u_steer (
    .clk   (clk),
    .rst_n (rst_n),
    .mix_i (mix_i),
    .sel_i (sel_vec),
    .pos_o (pos_o),
    .neg_o (neg_o)
  );

  ssd_wsum #(.N_UNIT(N_UNIT), .FRAC_W(FRAC_W), .SUM_W(SUM_W)) u_pos_sum (
    .vec_i (pos_o),
    .sum_o (pos_wsum)
  );

  ssd_wsum #(.N_UNIT(N_UNIT), .FRAC_W(FRAC_W), .SUM_W(SUM_W)) u_neg_sum (
    .vec_i (neg_o),
    .sum_o (neg_wsum)
  );
endmodule

// File: rtl/ssd_checker.sv
module ssd_checker #(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned FRAC_W = 2,
  localparam int unsigned UNARY_W = CODE_W - FRAC_W,
  localparam int unsigned N_UNIT  = 1 << UNARY_W,
  localparam int unsigned N_SLICE = N_UNIT + FRAC_W,
  localparam int unsigned TOTAL   = ssd_pkg::full_weight(CODE_W, FRAC_W),
  localparam int unsigned SUM_W   = $clog2(TOTAL + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CODE_W-1:0]  code_i,
  input logic               mix_i,
  input logic [N_UNIT-1:0]  unary_o,
  input logic [FRAC_W-1:0]  frac_o,
  input logic [N_SLICE-1:0] pos_o,
  input logic [N_SLICE-1:0] neg_o,
  input logic [SUM_W-1:0]   pos_wsum,
  input logic [SUM_W-1:0]   neg_wsum
);
  localparam logic [SUM_W-1:0] TOTAL_V = SUM_W'(TOTAL);

  // set once one full clock has passed out of reset, so $past is meaningful
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_therm_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (((unary_o + 1'b1) & unary_o) == '0));

  p_therm_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(unary_o) == int'(code_i[CODE_W-1:FRAC_W])));

  p_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pos_o & neg_o) == '0));

  p_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(mix_i)) |-> ((pos_o | neg_o) == '1));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(mix_i)) |-> (pos_o == '0 && neg_o == '0));

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(mix_i)) |->
      (pos_o[N_UNIT-1:0] == $past(unary_o) && pos_o[N_SLICE-1:N_UNIT] == $past(frac_o)));

  p_wsum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(mix_i)) |->
      (pos_wsum == SUM_W'($past(code_i)) && neg_wsum == TOTAL_V - SUM_W'($past(code_i))));
endmodule

bind slice_steer_decoder ssd_checker #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/slice_steer_decoder_tb.sv
module slice_steer_decoder_tb;
  localparam int CODE_W = 10;
  localparam int FRAC_W = 2;
  localparam int N_UNIT = 256;
  localparam int N_SLICE = N_UNIT + FRAC_W;
  localparam int TOTAL = 4 * N_UNIT + 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [CODE_W-1:0]  code_i = '0;
  logic               mix_i = 1'b0;
  logic [N_UNIT-1:0]  unary_o;
  logic [FRAC_W-1:0]  frac_o;
  logic [N_SLICE-1:0] pos_o;
  logic [N_SLICE-1:0] neg_o;

  int n_chk = 0;
  int n_err = 0;
  logic [N_SLICE-1:0] prev_pos = '0;
  logic [N_SLICE-1:0] prev_neg = '0;

  always #5 clk = ~clk;

  slice_steer_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .code_i(code_i), .mix_i(mix_i),
    .unary_o(unary_o), .frac_o(frac_o), .pos_o(pos_o), .neg_o(neg_o)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [N_SLICE-1:0] act, input logic [N_SLICE-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [N_UNIT-1:0] exp_unary(input int code);
    logic [N_UNIT-1:0] v = '0;
    for (int i = 0; i < N_UNIT; i++) v[i] = (i < (code / 4));
    return v;
  endfunction

  function automatic int wsum(input logic [N_SLICE-1:0] v);
    int s = 0;
    for (int i = 0; i < N_UNIT; i++) s += v[i] ? 4 : 0;
    s += v[N_UNIT] ? 1 : 0;
    s += v[N_UNIT+1] ? 2 : 0;
    return s;
  endfunction

  // called at a falling edge: drive, check the direct outputs, then the registered ones
  task automatic apply(input int code, input bit mix);
    logic [N_SLICE-1:0] ep;
    logic [N_SLICE-1:0] en;
    code_i = CODE_W'(code);
    mix_i  = mix;
    #1;
    chk(unary_o == exp_unary(code), "R1 unary", N_SLICE'(unary_o), N_SLICE'(exp_unary(code)));
    chk(frac_o == FRAC_W'(code % 4), "R2 frac", N_SLICE'(frac_o), N_SLICE'(code % 4));
    chk(pos_o == prev_pos && neg_o == prev_neg, "R3 held before edge", pos_o, prev_pos);
    ep = '0;
    if (mix) begin
      ep[N_UNIT-1:0] = exp_unary(code);
      ep[N_UNIT]     = code[0];
      ep[N_UNIT+1]   = code[1];
    end
    en = mix ? ~ep : '0;
    @(negedge clk);
    if (mix) begin
      chk(pos_o == ep, "R4 positive steering", pos_o, ep);
      chk(neg_o == en, "R5 negative complement", neg_o, en);
      chk(wsum(pos_o) == code, "R7 positive weight", N_SLICE'(wsum(pos_o)), N_SLICE'(code));
      chk(wsum(neg_o) == TOTAL - code, "R7 negative weight",
          N_SLICE'(wsum(neg_o)), N_SLICE'(TOTAL - code));
    end else begin
      chk(pos_o == '0 && neg_o == '0, "R6 idle outside mix", pos_o | neg_o, '0);
    end
    prev_pos = ep;
    prev_neg = en;
  endtask

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    code_i = 10'h3FF;
    mix_i  = 1'b1;
    repeat (3) @(negedge clk);
    chk(pos_o == '0 && neg_o == '0, "R8 reset state", pos_o | neg_o, '0);
    rst_n = 1'b1;
    mix_i = 1'b0;
    @(negedge clk);
    chk(pos_o == '0 && neg_o == '0, "R8 after release", pos_o | neg_o, '0);
    prev_pos = '0;
    prev_neg = '0;
    // boundary codes first
    apply(0, 1'b1);
    apply(3, 1'b1);
    apply(4, 1'b1);
    apply(1020, 1'b1);
    apply(1023, 1'b1);
    // exhaustive sweep with mix high, then with mix low
    for (int c = 0; c < 1024; c++) apply(c, 1'b1);
    for (int c = 0; c < 1024; c++) apply(c, 1'b0);
    // alternating strobe, descending codes
    for (int c = 1023; c >= 0; c -= 7) apply(c, c[0]);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule